// File: doc/BRIEF.md
# Excitable Spiking Node with Refractory Lockout

The block is a clocked model of an excitable cell. Several stimulus lines feed a merging stage that raises one combined level whenever any line is high. A rising edge of that combined level is a candidate event. The candidate is accepted only while the node is at rest. An accepted event launches two counters in the same clock edge. One drives the output spike for a fixed number of cycles. The other drives a longer lockout window, and during that window every further candidate is discarded.

Each clock cycle stands for one elementary gate delay. This lets a network of such nodes reproduce spike-and-recovery dynamics on a synchronous fabric. The spike width and the lockout width are parameters. Typical pairs are 4/10 and 10/20. The lockout is never shorter than the spike.

Top module: `exnode_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, both spike_o and refr_o are low.
- R2: When the OR of all stim_i bits goes from 0 in one sampled cycle to 1 in the next, and refr_o is low at that edge, spike_o goes high after that same clock edge. A single active line is enough.
- R3: Once raised, spike_o stays high for exactly SPIKE_W consecutive cycles and then returns low.
- R4: refr_o rises on the same clock edge as spike_o and stays high for exactly REFR_W consecutive cycles. Every spike has a matching lockout window.
- R5: A rising edge of the merged stimulus sampled while refr_o is high produces no spike and does not lengthen the current window. This includes an edge sampled on the last high cycle of refr_o.
- R6: A merged stimulus held high across the end of the lockout window does not fire the node again. Only a new 0-to-1 transition fires it.
- R7: A rising edge sampled in the first cycle in which refr_o reads low after a window is accepted.
- R8: Raising a second stim_i line while another line is already high, or dropping one line while another stays high, is not an edge and fires nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle equals one gate delay |
| rst_i | input | 1 | Synchronous reset, active high |
| stim_i | input | N_IN | Incoming stimulus lines, merged by OR |
| spike_o | output | 1 | Output spike, SPIKE_W cycles wide |
| refr_o | output | 1 | Lockout flag, REFR_W cycles wide |

## Verification
The bench builds the node with three input lines, a 4-cycle spike and a 10-cycle lockout. This gap is short enough that edges can be placed on both sides of the lockout boundary in a few cycles. The first setting of the pair allows candidate edges on the last locked cycle and on the first free cycle, and also allows second-line edges while a line is already held. Three lines are enough to show that any one line excites the node and that overlapping lines merge into a single level.

// File: rtl/exnode_pkg.sv
package exnode_pkg;

    // Running state of a one-shot width counter.
    typedef enum logic {
        PG_IDLE = 1'b0,
        PG_RUN  = 1'b1
    } pg_state_e;

    // Bits needed to hold the value n (at least one).
    function automatic int unsigned cnt_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/exnode_synapse.sv
module exnode_synapse #(
    parameter int unsigned N_IN = 3
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [N_IN-1:0] links_i,
    output logic            rise_o
);

    typedef struct packed {
        logic prev;
    } syn_state_t;

    syn_state_t s_d, s_q;
    logic       merged;

    always_comb begin
        merged   = |links_i;
        s_d      = s_q;
        s_d.prev = merged;
        rise_o   = merged & ~s_q.prev;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/exnode_gate.sv
module exnode_gate (
    input  logic rise_i,
    input  logic locked_i,
    output logic fire_o
);

    always_comb begin
        fire_o = rise_i & ~locked_i;
    end

endmodule

// File: rtl/exnode_pulse_gen.sv
module exnode_pulse_gen
    import exnode_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic trig_i,
    output logic pulse_o
);

    localparam int unsigned CW = cnt_bits(WIDTH - 1);
    localparam logic [CW-1:0] LOAD = CW'(WIDTH - 1);

    typedef struct packed {
        pg_state_e       st;
        logic [CW-1:0]   left;
    } pg_t;

    pg_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (trig_i) begin
            p_d.st   = PG_RUN;
            p_d.left = LOAD;
        end else if (p_q.st == PG_RUN) begin
            if (p_q.left == '0) begin
                p_d.st = PG_IDLE;
            end else begin
                p_d.left = p_q.left - 1'b1;
            end
        end
        pulse_o = (p_q.st == PG_RUN);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            p_q.st   <= PG_IDLE;
            p_q.left <= '0;
        end else begin
            p_q <= p_d;
        end
    end

endmodule

// File: rtl/exnode_top.sv
module exnode_top #(
    parameter int unsigned N_IN    = 3,
    parameter int unsigned SPIKE_W = 4,
    parameter int unsigned REFR_W  = 10
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [N_IN-1:0] stim_i,
    output logic            spike_o,
    output logic            refr_o
);

    localparam int unsigned N_GEN = 2;

    logic             rise;
    logic             fire;
    logic [N_GEN-1:0] pulses;

    if (SPIKE_W < 1 || REFR_W < SPIKE_W) begin : g_bad_cfg
        $error("exnode_top: lockout must be at least as long as a nonzero spike");
    end

    exnode_synapse #(
        .N_IN (N_IN)
    ) u_syn (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .links_i (stim_i),
        .rise_o  (rise)
    );

    exnode_gate u_gate (
        .rise_i   (rise),
        .locked_i (pulses[1]),
        .fire_o   (fire)
    );

    for (genvar g = 0; g < N_GEN; g++) begin : g_pgen
        localparam int unsigned W = (g == 0) ? SPIKE_W : REFR_W;
        exnode_pulse_gen #(
            .WIDTH (W)
        ) u_pg (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .trig_i  (fire),
            .pulse_o (pulses[g])
        );
    end

    always_comb begin
        spike_o = pulses[0];
        refr_o  = pulses[1];
    end

endmodule

// File: rtl/exnode_top_chk.sv
module exnode_top_chk #(
    parameter int unsigned N_IN    = 3,
    parameter int unsigned SPIKE_W = 4,
    parameter int unsigned REFR_W  = 10
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic [N_IN-1:0] stim_i,
    input logic            spike_o,
    input logic            refr_o
);

    localparam int unsigned SW = $clog2(SPIKE_W + 2);
    localparam int unsigned RW = $clog2(REFR_W + 2);

    logic          live_q;
    logic [SW-1:0] sp_len_q;
    logic [RW-1:0] rf_len_q;
    logic          any_stim;

    assign any_stim = |stim_i;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            live_q   <= 1'b0;
            sp_len_q <= '0;
            rf_len_q <= '0;
        end else begin
            live_q   <= 1'b1;
            sp_len_q <= spike_o ? sp_len_q + 1'b1 : '0;
            rf_len_q <= refr_o  ? rf_len_q + 1'b1 : '0;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk_i)
        $fell(rst_i) |-> (!spike_o && !refr_o)); // R1

    AST_EDGE_FIRES: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && !$past(any_stim) && any_stim && !refr_o) |=> $rose(spike_o)); // R2

    AST_SPIKE_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(spike_o) |-> (sp_len_q == SW'(SPIKE_W))); // R3

    AST_SPIKE_NO_OVERRUN: assert property (@(posedge clk_i) disable iff (rst_i)
        spike_o |-> (sp_len_q < SW'(SPIKE_W))); // R3

    AST_REFR_WITH_SPIKE: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(spike_o) |-> $rose(refr_o)); // R4

    AST_REFR_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(refr_o) |-> (rf_len_q == RW'(REFR_W))); // R4

    AST_LOCKED_REJECT: assert property (@(posedge clk_i) disable iff (rst_i)
        refr_o |=> !$rose(spike_o)); // R5

    AST_HELD_NO_REFIRE: assert property (@(posedge clk_i) disable iff (rst_i)
        (live_q && $past(any_stim) && any_stim) |=> !$rose(spike_o)); // R6

endmodule

bind exnode_top exnode_top_chk #(
    .N_IN    (N_IN),
    .SPIKE_W (SPIKE_W),
    .REFR_W  (REFR_W)
) u_chk (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .stim_i  (stim_i),
    .spike_o (spike_o),
    .refr_o  (refr_o)
);

// File: tb/exnode_top_tb.sv
`timescale 1ns/1ps
module exnode_top_tb;

    localparam int unsigned N_IN    = 3;
    localparam int unsigned SPIKE_W = 4;
    localparam int unsigned REFR_W  = 10;
    localparam time         CLK_P   = 20ns;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N_IN-1:0] stim = '0;
    logic            spike_o, refr_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int rises  = 0;
    int sq[$];
    int rq[$];

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    exnode_top #(
        .N_IN    (N_IN),
        .SPIKE_W (SPIKE_W),
        .REFR_W  (REFR_W)
    ) u_dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .stim_i  (stim),
        .spike_o (spike_o),
        .refr_o  (refr_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Driver: applies a stimulus pattern at a falling edge and, when a spike
    // is expected, records the cycle in which it must appear.
    task automatic set_stim(input logic [N_IN-1:0] m, input bit exp, output int c);
        @(negedge clk);
        stim = m;
        c    = cyc;
        if (exp) begin
            sq.push_back(c + 1);
            rq.push_back(c + 1);
        end
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    // Monitor: measures every spike and lockout window and compares them
    // against the scoreboard entries.
    logic sp_prev = 1'b0, rf_prev = 1'b0;
    int   sp_start = 0, rf_start = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (spike_o && !sp_prev) begin
                rises++;
                sp_start = cyc;
                if (sq.size() == 0) chk(1'b0, "R5 unexpected spike", cyc, -1);
                else begin
                    int e;
                    e = sq.pop_front();
                    chk(cyc == e, "R2 spike start", cyc, e);
                end
            end
            if (!spike_o && sp_prev)
                chk(cyc - sp_start == SPIKE_W, "R3 spike width", cyc - sp_start, SPIKE_W);
            if (refr_o && !rf_prev) begin
                rf_start = cyc;
                if (rq.size() == 0) chk(1'b0, "R4 unexpected window", cyc, -1);
                else begin
                    int e;
                    e = rq.pop_front();
                    chk(cyc == e, "R4 window start", cyc, e);
                end
            end
            if (!refr_o && rf_prev)
                chk(cyc - rf_start == REFR_W, "R4 window width", cyc - rf_start, REFR_W);
            sp_prev = spike_o;
            rf_prev = refr_o;
        end
    end

    initial begin
        #(CLK_P * 100000);
        chk(1'b0, "watchdog", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int c, c2, d;
        repeat (4) @(negedge clk);
        chk(!spike_o, "R1 spike in reset", spike_o, 0);
        chk(!refr_o,  "R1 lockout in reset", refr_o, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!spike_o, "R1 spike after reset", spike_o, 0);
        chk(!refr_o,  "R1 lockout after reset", refr_o, 0);

        // R2: single line excites the node
        set_stim(3'b001, 1'b1, c);
        set_stim(3'b000, 1'b0, d);
        wait_to(c + 14);
        chk(rises == 1, "R2 spike count", rises, 1);

        // R5: edges inside the window, including its last locked cycle
        set_stim(3'b100, 1'b1, c);
        set_stim(3'b000, 1'b0, d);
        wait_to(c + 2);
        set_stim(3'b010, 1'b0, d);
        set_stim(3'b000, 1'b0, d);
        wait_to(c + 9);
        set_stim(3'b001, 1'b0, c2);
        chk(c2 == c + REFR_W, "R5 boundary placement", c2, c + REFR_W);
        set_stim(3'b000, 1'b0, d);
        wait_to(c + 24);
        chk(rises == 2, "R5 spike count", rises, 2);

        // R7: edge in the first free cycle is accepted
        set_stim(3'b010, 1'b1, c);
        set_stim(3'b000, 1'b0, d);
        wait_to(c + 10);
        set_stim(3'b001, 1'b1, c2);
        chk(c2 == c + REFR_W + 1, "R7 boundary placement", c2, c + REFR_W + 1);
        set_stim(3'b000, 1'b0, d);
        wait_to(c2 + 14);
        chk(rises == 4, "R7 spike count", rises, 4);

        // R6: held stimulus does not refire
        set_stim(3'b100, 1'b1, c);
        wait_to(c + 30);
        chk(rises == 5, "R6 held count", rises, 5);
        set_stim(3'b000, 1'b0, d);
        set_stim(3'b100, 1'b1, c);
        set_stim(3'b000, 1'b0, d);
        wait_to(c + 14);
        chk(rises == 6, "R6 fresh edge count", rises, 6);

        // R8: overlapping lines merge into one level
        set_stim(3'b001, 1'b1, c);
        wait_to(c + 3);
        set_stim(3'b011, 1'b0, d);
        wait_to(c + 15);
        set_stim(3'b010, 1'b0, d);
        wait_to(c + 20);
        chk(rises == 7, "R8 overlap count", rises, 7);
        set_stim(3'b000, 1'b0, d);
        set_stim(3'b010, 1'b1, c2);
        set_stim(3'b000, 1'b0, d);
        wait_to(c2 + 14);
        chk(rises == 8, "R8 spike count", rises, 8);

        chk(sq.size() == 0, "R2 missing spikes", sq.size(), 0);
        chk(rq.size() == 0, "R4 missing windows", rq.size(), 0);
        chk(!spike_o && !refr_o, "R4 quiet at end", {spike_o, refr_o}, 0);

        summary();
        $finish;
    end

endmodule